// File: doc/BRIEF.md
# Triggered Pipeline Pointer Manager

This block steers a circular store of 48 sample slots. Each advance pulse writes the current sample into the slot under the write pointer, then moves the pointer forward. A trigger pointer trails the write pointer by a programmable distance, so it names the slot that was filled that many advances earlier.

A trigger pulse locks the slot under the trigger pointer so later passes of the write pointer leave it alone. The same pulse queues the slot number in a four-entry queue. Readout logic reads the oldest locked slot from the queue head. When it has finished with that slot, it pulses the release input, which unlocks the slot and pops the queue.

A small state machine tracks queue occupancy:
- `FQ_EMPTY` goes to `FQ_PART` on an accepted trigger.
- `FQ_PART` goes to `FQ_FULL` when the fourth entry lands.
- `FQ_PART` goes to `FQ_EMPTY` when the last entry is released.
- `FQ_FULL` goes back to `FQ_PART` on a release without a new trigger.
- A release and a trigger in the same cycle keep `FQ_FULL`.
- Pipeline clear returns every state to `FQ_EMPTY`.

Top module: `tsp_ptr_mgr`

## Requirements
- R1: After `rst_n` low, or after a cycle with `pipe_clear` high, the outputs return to their cleared values: `wr_slot` is 0, `protect_mask` is all zero, `held_count` is 0, `head_valid` is 0 and `overflow` is 0. `pipe_clear` overrides every other input in its cycle.
- R2: A cycle with `adv` high moves `wr_slot` to the next slot (47 wraps to 0). Without `adv`, `wr_slot` holds.
- R3: `trig_slot` equals (`wr_slot` − L) mod 48, with L = `latency` when `latency` < 48 and L = 47 otherwise.
- R4: A `trig` on an unlocked slot while the queue has room has two effects:
  - it sets bit `trig_slot` of `protect_mask`;
  - it appends that slot number to the queue, so `held_count` rises by 1.
- R5: When the write pointer advances, it skips every locked slot and lands on the first unlocked slot after its current position.
- R6: A `trig` while `protect_mask[trig_slot]` is already 1 changes neither `protect_mask`, `held_count` nor `overflow`.
- R7: A `trig` on an unlocked slot while `held_count` is 4, with no `clr` in that cycle, is dropped: the mask bit stays 0. It also sets `overflow`, which then stays 1 until R1 clears it.
- R8: `clr` with a non-empty queue releases slots in trigger order. It clears the mask bit of the slot at the queue head, lowers `held_count` by 1 and moves `head_slot` to the next-oldest entry.
- R9: `clr` with an empty queue changes nothing.
- R10: With a full queue, `clr` and `trig` (on an unlocked slot) in the same cycle both act: the head is released, the new slot is appended, `held_count` stays 4 and `overflow` stays 0.
- R11: `head_valid` is 1 exactly when `held_count` is non-zero, and `head_slot` then names the oldest locked slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_clear | input | 1 | Synchronous clear of pointers, locks and queue |
| adv | input | 1 | Pipeline advance: write current slot, move pointers |
| trig | input | 1 | Lock the slot under the trigger pointer |
| clr | input | 1 | Release the oldest locked slot |
| latency | input | 6 | Distance of trigger pointer behind write pointer |
| wr_slot | output | 6 | Slot written on the next advance |
| trig_slot | output | 6 | Slot a trigger would lock now |
| head_valid | output | 1 | Queue holds at least one slot |
| head_slot | output | 6 | Oldest locked slot |
| held_count | output | 3 | Number of locked slots |
| overflow | output | 1 | Sticky: a trigger was dropped on a full queue |
| protect_mask | output | 48 | One lock flag per slot |

## Verification
Four properties are checked on every cycle:
- the number of set lock flags always equals the queue count;
- the write pointer never comes to rest on a locked slot;
- the overflow flag never falls without a clear;
- a released head slot is unlocked in the following cycle.

Some behaviour is visible only through the bench's scenarios: the exact landing slot after a wrap past several adjacent locks, the first-in first-out release order, latency clamping, and the simultaneous release-and-trigger case on a full queue.

// File: rtl/tsp_pkg.sv
package tsp_pkg;

    typedef enum logic [1:0] {
        FQ_EMPTY = 2'd0,
        FQ_PART  = 2'd1,
        FQ_FULL  = 2'd2
    } fq_state_e;

    // modular add of two non-negative values below n
    function automatic int wrap_add(int a, int b, int n);
        int s;
        s = a + b;
        return (s >= n) ? s - n : s;
    endfunction

endpackage

// File: rtl/tsp_slot_flags.sv
module tsp_slot_flags #(
    parameter int DEPTH  = 48,
    parameter int SLOT_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_clear,
    input  logic              set_en,
    input  logic [SLOT_W-1:0] set_slot,
    input  logic              rel_en,
    input  logic [SLOT_W-1:0] rel_slot,
    output logic [DEPTH-1:0]  mask_q,
    output logic [DEPTH-1:0]  mask_d
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_flag
        always_comb begin
            if (pipe_clear) begin
                mask_d[i] = 1'b0;
            end else if (set_en && (set_slot == SLOT_W'(i))) begin
                mask_d[i] = 1'b1;
            end else if (rel_en && (rel_slot == SLOT_W'(i))) begin
                mask_d[i] = 1'b0;
            end else begin
                mask_d[i] = mask_q[i];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q[i] <= 1'b0;
            end else begin
                mask_q[i] <= mask_d[i];
            end
        end
    end

    // R6: setting a flag never targets one already set
    a_r6_set_only_free: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> !mask_q[set_slot]);

endmodule

// File: rtl/tsp_write_ptr.sv
module tsp_write_ptr #(
    parameter int DEPTH  = 48,
    parameter int LOOK   = 5,
    parameter int SLOT_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_clear,
    input  logic              adv,
    input  logic [DEPTH-1:0]  mask_d,
    output logic [SLOT_W-1:0] wp_q
);
    import tsp_pkg::*;

    logic [SLOT_W-1:0] nxt;
    logic [SLOT_W-1:0] cand;
    logic              found;

    // search the next LOOK slots for the first unlocked one
    always_comb begin
        nxt   = SLOT_W'(wrap_add(int'(wp_q), 1, DEPTH));
        cand  = nxt;
        found = 1'b0;
        for (int k = 1; k <= LOOK; k++) begin
            cand = SLOT_W'(wrap_add(int'(wp_q), k, DEPTH));
            if (!found && !mask_d[cand]) begin
                nxt   = cand;
                found = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q <= '0;
        end else if (pipe_clear) begin
            wp_q <= '0;
        end else if (adv) begin
            wp_q <= nxt;
        end
    end

    // R2: an advance always moves the pointer
    a_r2_wp_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !pipe_clear) |=> (wp_q != $past(wp_q)));

    // R2: no advance, no movement
    a_r2_wp_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !pipe_clear) |=> $stable(wp_q));

endmodule

// File: rtl/tsp_addr_fifo.sv
module tsp_addr_fifo #(
    parameter int FIFO_DEPTH = 4,
    parameter int SLOT_W     = 6,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1),
    parameter int IDX_W      = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_clear,
    input  logic              push,
    input  logic [SLOT_W-1:0] push_slot,
    input  logic              pop,
    output logic [SLOT_W-1:0] head_slot,
    output logic [CNT_W-1:0]  count,
    output logic              head_valid,
    output logic              full
);
    import tsp_pkg::*;

    fq_state_e         state_q, state_d;
    logic [SLOT_W-1:0] store [FIFO_DEPTH];
    logic [IDX_W-1:0]  rd_q, wr_q;
    logic [CNT_W-1:0]  count_d;

    function automatic logic [IDX_W-1:0] bump(logic [IDX_W-1:0] p);
        return (int'(p) == FIFO_DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        count_d = count;
        if (push && !pop) count_d = count + 1'b1;
        if (pop && !push) count_d = count - 1'b1;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FQ_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (pipe_clear) begin
            state_d = FQ_EMPTY;
        end else begin
            unique case (state_q)
                FQ_EMPTY: if (push)
                    state_d = (int'(count_d) == FIFO_DEPTH) ? FQ_FULL : FQ_PART;
                FQ_PART: begin
                    if (count_d == '0) state_d = FQ_EMPTY;
                    else if (int'(count_d) == FIFO_DEPTH) state_d = FQ_FULL;
                end
                FQ_FULL: if (pop && !push)
                    state_d = (count_d == '0) ? FQ_EMPTY : FQ_PART;
                default: state_d = FQ_EMPTY;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        head_valid = 1'b0;
        full       = 1'b0;
        unique case (state_q)
            FQ_EMPTY: ;
            FQ_PART:  head_valid = 1'b1;
            FQ_FULL: begin
                head_valid = 1'b1;
                full       = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            count <= '0;
        end else if (pipe_clear) begin
            rd_q  <= '0;
            wr_q  <= '0;
            count <= '0;
        end else begin
            count <= count_d;
            if (push) wr_q <= bump(wr_q);
            if (pop)  rd_q <= bump(rd_q);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !pipe_clear) store[wr_q] <= push_slot;
    end

    assign head_slot = store[rd_q];

    // R11: state and count agree
    a_r11_state_count: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid == (count != '0)) && (full == (int'(count) == FIFO_DEPTH)));

    // R7: never above capacity
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= FIFO_DEPTH);

    // R9: pop never requested on an empty queue
    a_r9_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_valid);

endmodule

// File: rtl/tsp_ptr_mgr.sv
module tsp_ptr_mgr #(
    parameter int DEPTH      = 48,
    parameter int FIFO_DEPTH = 4,
    parameter int SLOT_W     = $clog2(DEPTH),
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_clear,
    input  logic              adv,
    input  logic              trig,
    input  logic              clr,
    input  logic [SLOT_W-1:0] latency,
    output logic [SLOT_W-1:0] wr_slot,
    output logic [SLOT_W-1:0] trig_slot,
    output logic              head_valid,
    output logic [SLOT_W-1:0] head_slot,
    output logic [CNT_W-1:0]  held_count,
    output logic              overflow,
    output logic [DEPTH-1:0]  protect_mask
);
    import tsp_pkg::*;

    localparam int LOOK = FIFO_DEPTH + 1;

    logic [SLOT_W-1:0] lat_eff;
    logic [DEPTH-1:0]  mask_d;
    logic              already, full, pop, push, drop;

    always_comb begin
        lat_eff   = (int'(latency) >= DEPTH) ? SLOT_W'(DEPTH - 1) : latency;
        trig_slot = SLOT_W'(wrap_add(int'(wr_slot), DEPTH - int'(lat_eff), DEPTH));
        already   = protect_mask[trig_slot];
        pop       = clr && head_valid && !pipe_clear;
        push      = trig && !already && !pipe_clear && (!full || pop);
        drop      = trig && !already && !pipe_clear && full && !pop;
    end

    tsp_slot_flags #(.DEPTH(DEPTH), .SLOT_W(SLOT_W)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .pipe_clear (pipe_clear),
        .set_en     (push),
        .set_slot   (trig_slot),
        .rel_en     (pop),
        .rel_slot   (head_slot),
        .mask_q     (protect_mask),
        .mask_d     (mask_d)
    );

    tsp_write_ptr #(.DEPTH(DEPTH), .LOOK(LOOK), .SLOT_W(SLOT_W)) u_wptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .pipe_clear (pipe_clear),
        .adv        (adv),
        .mask_d     (mask_d),
        .wp_q       (wr_slot)
    );

    tsp_addr_fifo #(.FIFO_DEPTH(FIFO_DEPTH), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .pipe_clear (pipe_clear),
        .push       (push),
        .push_slot  (trig_slot),
        .pop        (pop),
        .head_slot  (head_slot),
        .count      (held_count),
        .head_valid (head_valid),
        .full       (full)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overflow <= 1'b0;
        end else if (pipe_clear) begin
            overflow <= 1'b0;
        end else if (drop) begin
            overflow <= 1'b1;
        end
    end

    // R4: locks and queue entries stay one-to-one
    a_r4_mask_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(protect_mask) == int'(held_count));

    // R5: the write pointer never rests on a locked slot after moving
    a_r5_lands_free: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !pipe_clear) |=> !protect_mask[wr_slot]);

    // R7: overflow is sticky
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !pipe_clear) |=> overflow);

    // R8: a released head is unlocked next cycle
    a_r8_release_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && head_valid && !pipe_clear) |=> !protect_mask[$past(head_slot)]);

    // R1: clear empties everything
    a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_clear |=> (wr_slot == '0) && (protect_mask == '0) && !overflow);

endmodule

// File: tb/tsp_ptr_mgr_tb.sv
module tsp_ptr_mgr_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pipe_clear = 1'b0;
    logic        adv = 1'b0;
    logic        trig = 1'b0;
    logic        clr = 1'b0;
    logic [5:0]  latency = 6'd3;
    logic [5:0]  wr_slot, trig_slot, head_slot;
    logic        head_valid, overflow;
    logic [2:0]  held_count;
    logic [47:0] protect_mask;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tsp_ptr_mgr u_dut (
        .clk (clk), .rst_n (rst_n), .pipe_clear (pipe_clear),
        .adv (adv), .trig (trig), .clr (clr), .latency (latency),
        .wr_slot (wr_slot), .trig_slot (trig_slot), .head_valid (head_valid),
        .head_slot (head_slot), .held_count (held_count), .overflow (overflow),
        .protect_mask (protect_mask)
    );

    typedef struct packed {
        logic       a;
        logic       t;
        logic       c;
        logic [5:0] wr;
        logic [5:0] hd;
        logic [2:0] cnt;
        logic       ovf;
    } vec_t;

    // latency 3, starting from cleared state
    localparam vec_t TBL [8] = '{
        '{1'b1, 1'b0, 1'b0, 6'd1, 6'd0, 3'd0, 1'b0},  // R2
        '{1'b1, 1'b0, 1'b0, 6'd2, 6'd0, 3'd0, 1'b0},  // R2
        '{1'b1, 1'b0, 1'b0, 6'd3, 6'd0, 3'd0, 1'b0},  // R2
        '{1'b0, 1'b1, 1'b0, 6'd3, 6'd0, 3'd1, 1'b0},  // R4 lock slot 0
        '{1'b1, 1'b1, 1'b0, 6'd4, 6'd0, 3'd1, 1'b0},  // R6 slot 0 again
        '{1'b0, 1'b1, 1'b0, 6'd4, 6'd0, 3'd2, 1'b0},  // R4 lock slot 1
        '{1'b0, 1'b0, 1'b1, 6'd4, 6'd1, 3'd1, 1'b0},  // R8 release 0
        '{1'b0, 1'b1, 1'b0, 6'd4, 6'd1, 3'd1, 1'b0}   // R6 slot 1 again
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic a, input logic t, input logic c);
        @(negedge clk);
        adv = a; trig = t; clr = c;
        @(posedge clk);
        #1;
        adv = 1'b0; trig = 1'b0; clr = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state, R3 trigger distance
        chk("R1 wr_slot", wr_slot, 0);
        chk("R1 held_count", held_count, 0);
        chk("R1 mask", int'(protect_mask != 0), 0);
        chk("R1 overflow", overflow, 0);
        chk("R11 head_valid", head_valid, 0);
        chk("R3 trig_slot", trig_slot, 45);

        foreach (TBL[i]) begin
            cyc(TBL[i].a, TBL[i].t, TBL[i].c);
            chk($sformatf("R2 wr row%0d", i), wr_slot, TBL[i].wr);
            chk($sformatf("R4 cnt row%0d", i), held_count, TBL[i].cnt);
            chk($sformatf("R7 ovf row%0d", i), overflow, TBL[i].ovf);
            chk($sformatf("R3 trig row%0d", i), trig_slot, (int'(TBL[i].wr) + 45) % 48);
            chk($sformatf("R11 valid row%0d", i), head_valid, int'(TBL[i].cnt != 0));
            if (TBL[i].cnt != 0)
                chk($sformatf("R8 head row%0d", i), head_slot, TBL[i].hd);
        end
        chk("R6 mask after repeats", int'(protect_mask), 2);

        // R5 wrap past a single lock at slot 1
        for (int k = 0; k < 44; k++) cyc(1'b1, 1'b0, 1'b0);
        chk("R2 wrap to 0", wr_slot, 0);
        cyc(1'b1, 1'b0, 1'b0);
        chk("R5 skip slot 1", wr_slot, 2);

        // fill the queue with latency 0
        latency = 6'd0;
        do_reset();
        cyc(1'b0, 1'b1, 1'b0);
        for (int k = 0; k < 3; k++) begin
            cyc(1'b1, 1'b0, 1'b0);
            cyc(1'b0, 1'b1, 1'b0);
        end
        chk("R4 full count", held_count, 4);
        cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b0, 1'b1, 1'b0);
        chk("R7 dropped count", held_count, 4);
        chk("R7 dropped mask bit", protect_mask[4], 0);
        chk("R7 overflow set", overflow, 1);
        // R10 release and trigger together on a full queue
        cyc(1'b0, 1'b1, 1'b1);
        chk("R10 count", held_count, 4);
        chk("R10 head", head_slot, 1);
        chk("R10 mask", int'(protect_mask[15:0]), 16'h001E);
        // R5 skip a run of four locks (1..4)
        for (int k = 0; k < 44; k++) cyc(1'b1, 1'b0, 1'b0);
        chk("R5 land on 0", wr_slot, 0);
        cyc(1'b1, 1'b0, 1'b0);
        chk("R5 skip run", wr_slot, 5);
        // R8 release order
        for (int k = 1; k <= 4; k++) begin
            chk($sformatf("R8 head before release %0d", k), head_slot, k);
            cyc(1'b0, 1'b0, 1'b1);
            chk($sformatf("R8 count after release %0d", k), held_count, 4 - k);
        end
        chk("R11 empty valid", head_valid, 0);
        cyc(1'b0, 1'b0, 1'b1);
        chk("R9 empty clr count", held_count, 0);
        chk("R9 empty clr mask", int'(protect_mask != 0), 0);
        chk("R7 still sticky", overflow, 1);

        // R1 pipe_clear, overriding an advance
        @(negedge clk);
        pipe_clear = 1'b1; adv = 1'b1;
        @(posedge clk);
        #1;
        pipe_clear = 1'b0; adv = 1'b0;
        chk("R1 clear wr", wr_slot, 0);
        chk("R1 clear ovf", overflow, 0);

        // R3 latency clamp
        latency = 6'd60;
        #1;
        chk("R3 clamp", trig_slot, 1);
        latency = 6'd5;
        #1;
        chk("R3 lat5", trig_slot, 43);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule